// File: doc/BRIEF.md
# Write-Back Data Cache Controller

This block is a direct-mapped level-1 data cache with a write-back, write-allocate policy. A CPU issues one load or store at a time by raising a read or write strobe together with a byte address, store data and a byte mask. It holds that request while the cache drives `cpu_stall` high. On the memory side the cache moves whole lines as several word-wide beats. A memory-side `mem_stall` input holds any beat for as long as it is asserted.

After reset the controller walks through every set and clears its valid and dirty flags. It then waits for work. A request first gets a tag check. On a miss, the cache first writes a dirty victim back to memory, then refills the line, then checks the tag again and serves the request from the cache. Loads complete in the tag-check cycle. Stores complete in that same cycle, and their bytes are merged into the line one cycle later. A request that arrives while the controller is still busy goes straight to a tag check without passing through the idle state.

The default geometry is a 12-bit byte address, 32-bit words, 4 words per line and 8 sets. Address bits [1:0] select the byte, [3:2] the word, [6:4] the set and [11:7] form the tag.

Top module: `wbdc_top`

## Requirements
- R1: After reset is released, `cpu_stall` stays high while all sets are swept (between SETS and SETS+3 cycles, including two cycles of reset synchronization). Afterwards every line is invalid, so the first access to any line misses.
- R2: In the idle state `cpu_stall` is low while neither strobe is high. A request seen in idle raises `cpu_stall` for that cycle and gets a tag check in the next cycle, so a hit issued from idle completes in 2 cycles.
- R3: A load that hits completes with `cpu_stall` low in its tag-check cycle, with the addressed word on `cpu_rdata` and no memory strobe. Issued right after another completed hit, it takes 1 cycle.
- R4: A miss refills the line in LINE_WORDS beats with `mem_rd` high. The address of each beat is {requested tag, set, beat number, 2'b00}. A beat completes, and `mem_rdata` is taken, only in a cycle where `mem_stall` is low.
- R5: On a miss whose victim is valid and dirty, the victim is first written back in LINE_WORDS beats with `mem_wr` high and `mem_mask` all ones. The address of each beat is {victim tag, set, beat number, 2'b00}. The refill follows the write-back.
- R6: A refilled line is valid and clean. Evicting it later causes no write-back beats.
- R7: A store completes with `cpu_stall` low in a hit cycle, then one merge cycle follows with `cpu_stall` high. Byte i of the word (bits 8i+7:8i) is replaced only where `cpu_mask[i]` is 1, so byte, half-word and word stores are all expressed through the mask.
- R8: A merged store marks its line dirty, and the stored bytes reach memory when that line is evicted.
- R9: After the merge cycle, a pending request goes directly to a tag check, so a load that hits right after a store completes in 2 cycles.
- R10: `mem_rd` and `mem_wr` are never high together. `mem_mask` is all ones whenever `mem_wr` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | ADDR_W | Byte address of the request |
| cpu_wdata | input | WORD_W | Store data |
| cpu_mask | input | WORD_W/8 | Byte enables of a store |
| cpu_rd | input | 1 | Load strobe |
| cpu_wr | input | 1 | Store strobe |
| cpu_rdata | output | WORD_W | Load data, valid when a load completes |
| cpu_stall | output | 1 | Request not yet complete |
| mem_addr | output | ADDR_W | Byte address of the current beat |
| mem_wdata | output | WORD_W | Write-back data |
| mem_mask | output | WORD_W/8 | Byte enables of a write beat |
| mem_rd | output | 1 | Refill beat request |
| mem_wr | output | 1 | Write-back beat request |
| mem_rdata | input | WORD_W | Refill data |
| mem_stall | input | 1 | Holds the current beat |

## Verification
The hardest case to reach is a dirty-victim eviction whose write-back carries bytes merged by earlier partial stores. To get there, the bench first fills one set with a load miss, then applies byte and half-word stores to that line, then loads from an address with a different tag in the same set. The memory model toggles `mem_stall` on every cycle during the first refill, so held beats are exercised. The bench's model memory is compared word by word with the expected merged line after the write-back. A second eviction of the now-clean line then checks that no write-back beats occur.

// File: rtl/wbdc_pkg.sv
package wbdc_pkg;
  typedef enum logic [2:0] {
    ST_FLUSH = 3'd0,
    ST_IDLE  = 3'd1,
    ST_COMP  = 3'd2,
    ST_WBACK = 3'd3,
    ST_FILL  = 3'd4,
    ST_UPD   = 3'd5
  } wbdc_state_e;
endpackage

// File: rtl/wbdc_tag_store.sv
module wbdc_tag_store #(
  parameter int SETS  = 8,
  parameter int TAG_W = 5,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_valid,
  output logic             rd_dirty,
  output logic [TAG_W-1:0] rd_tag,
  input  logic             clr_en,
  input  logic [IDX_W-1:0] clr_idx,
  input  logic             fill_en,
  input  logic [IDX_W-1:0] fill_idx,
  input  logic [TAG_W-1:0] fill_tag,
  input  logic             dirty_en,
  input  logic [IDX_W-1:0] dirty_idx
);
  logic [SETS-1:0]  valid_q;
  logic [SETS-1:0]  dirty_q;
  logic [TAG_W-1:0] tag_q [SETS];

  always_ff @(posedge clk) begin
    for (int s = 0; s < SETS; s++) begin
      if (clr_en && clr_idx == IDX_W'(s)) begin
        valid_q[s] <= 1'b0;
        dirty_q[s] <= 1'b0;
      end else if (fill_en && fill_idx == IDX_W'(s)) begin
        valid_q[s] <= 1'b1;
        dirty_q[s] <= 1'b0;
        tag_q[s]   <= fill_tag;
      end else if (dirty_en && dirty_idx == IDX_W'(s)) begin
        dirty_q[s] <= 1'b1;
      end
    end
  end

  assign rd_valid = valid_q[rd_idx];
  assign rd_dirty = dirty_q[rd_idx];
  assign rd_tag   = tag_q[rd_idx];

  // R6: a refilled line is valid and clean
  p_fill_clean_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |=> (valid_q[$past(fill_idx)] && !dirty_q[$past(fill_idx)]));

  // R8: a merged store marks its line dirty
  p_store_dirty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dirty_en && !fill_en && !clr_en) |=> dirty_q[$past(dirty_idx)]);
endmodule

// File: rtl/wbdc_line_store.sv
module wbdc_line_store #(
  parameter int SETS       = 8,
  parameter int LINE_WORDS = 4,
  parameter int WORD_W     = 32,
  localparam int IDX_W  = $clog2(SETS),
  localparam int WOFF_W = $clog2(LINE_WORDS),
  localparam int BYTES  = WORD_W / 8,
  localparam int DEPTH  = SETS * LINE_WORDS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_set,
  input  logic [WOFF_W-1:0] rd_word,
  output logic [WORD_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_set,
  input  logic [WOFF_W-1:0] wr_word,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [BYTES-1:0]  wr_be
);
  logic [WORD_W-1:0] words_q [DEPTH];
  logic [IDX_W+WOFF_W-1:0] wa;
  logic [WORD_W-1:0] old_word;
  logic [WORD_W-1:0] merged;

  assign wa       = {wr_set, wr_word};
  assign old_word = words_q[wa];

  for (genvar b = 0; b < BYTES; b++) begin : g_merge
    assign merged[b*8 +: 8] = wr_be[b] ? wr_data[b*8 +: 8] : old_word[b*8 +: 8];
  end

  always_ff @(posedge clk) begin
    if (wr_en) words_q[wa] <= merged;
  end

  assign rd_data = words_q[{rd_set, rd_word}];

  // R7: a byte lane outside the mask keeps its old contents
  p_merge_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_be[0]) |=> (words_q[$past(wa)][7:0] == $past(old_word[7:0])));
endmodule

// File: rtl/wbdc_ctrl.sv
module wbdc_ctrl
  import wbdc_pkg::*;
#(
  parameter int SETS       = 8,
  parameter int LINE_WORDS = 4,
  localparam int IDX_W  = $clog2(SETS),
  localparam int WOFF_W = $clog2(LINE_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_rd,
  input  logic              req_wr,
  input  logic              hit,
  input  logic              victim_dirty,
  input  logic              mem_stall,
  output wbdc_state_e       state,
  output logic [WOFF_W-1:0] beat,
  output logic [IDX_W-1:0]  flush_idx,
  output logic              clr_en,
  output logic              fill_word_en,
  output logic              fill_done,
  output logic              latch_en,
  output logic              upd_en,
  output logic              cpu_stall,
  output logic              mem_rd,
  output logic              mem_wr
);
  localparam logic [WOFF_W-1:0] LAST_BEAT = WOFF_W'(LINE_WORDS - 1);
  localparam logic [IDX_W-1:0]  LAST_SET  = IDX_W'(SETS - 1);

  wbdc_state_e       state_q, state_d;
  logic [WOFF_W-1:0] beat_q, beat_d;
  logic [IDX_W-1:0]  flush_q, flush_d;
  logic              req, beat_go, beat_en, flush_en;

  assign req     = req_rd | req_wr;
  assign beat_go = (state_q == ST_WBACK || state_q == ST_FILL) && !mem_stall;

  always_comb begin
    state_d      = state_q;
    clr_en       = 1'b0;
    fill_word_en = 1'b0;
    fill_done    = 1'b0;
    latch_en     = 1'b0;
    upd_en       = 1'b0;
    cpu_stall    = 1'b1;
    mem_rd       = 1'b0;
    mem_wr       = 1'b0;
    case (state_q)
      ST_FLUSH: begin
        clr_en = 1'b1;
        if (flush_q == LAST_SET) state_d = ST_IDLE;
      end
      ST_IDLE: begin
        cpu_stall = req;
        if (req) state_d = ST_COMP;
      end
      ST_COMP: begin
        cpu_stall = req && !hit;
        if (!req)              state_d = ST_IDLE;
        else if (hit) begin
          if (req_wr) begin
            latch_en = 1'b1;
            state_d  = ST_UPD;
          end
        end
        else if (victim_dirty) state_d = ST_WBACK;
        else                   state_d = ST_FILL;
      end
      ST_WBACK: begin
        mem_wr = 1'b1;
        if (!mem_stall && beat_q == LAST_BEAT) state_d = ST_FILL;
      end
      ST_FILL: begin
        mem_rd       = 1'b1;
        fill_word_en = !mem_stall;
        if (!mem_stall && beat_q == LAST_BEAT) begin
          fill_done = 1'b1;
          state_d   = req ? ST_COMP : ST_IDLE;
        end
      end
      ST_UPD: begin
        upd_en  = 1'b1;
        state_d = req ? ST_COMP : ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    beat_en = 1'b0;
    beat_d  = beat_q;
    if (state_q == ST_COMP) begin
      beat_en = 1'b1;
      beat_d  = '0;
    end else if (beat_go) begin
      beat_en = 1'b1;
      beat_d  = beat_q + 1'b1;
    end
    flush_en = (state_q == ST_FLUSH);
    flush_d  = flush_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_FLUSH;
      beat_q  <= '0;
      flush_q <= '0;
    end else begin
      state_q <= state_d;
      if (beat_en)  beat_q  <= beat_d;
      if (flush_en) flush_q <= flush_d;
    end
  end

  assign state     = state_q;
  assign beat      = beat_q;
  assign flush_idx = flush_q;

  // R1: the CPU is held during the reset sweep
  p_flush_stall_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FLUSH) |-> cpu_stall);

  // R2: a request seen in idle gets a tag check next cycle
  p_idle_wake_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && req) |=> (state_q == ST_COMP));

  // R4: a held beat keeps its number
  p_beat_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_FILL || state_q == ST_WBACK) && mem_stall) |=> $stable(beat_q));

  // R5: the last write-back beat hands over to the refill
  p_wback_then_fill_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WBACK && !mem_stall && beat_q == LAST_BEAT) |=> (state_q == ST_FILL));

  // R9: a pending request after the merge goes straight to a tag check
  p_upd_chain_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_UPD && req) |=> (state_q == ST_COMP));

  // R10: memory strobes are exclusive
  p_strobe_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));
endmodule

// File: rtl/wbdc_top.sv
module wbdc_top
  import wbdc_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int WORD_W     = 32,
  parameter int LINE_WORDS = 4,
  parameter int SETS       = 8,
  localparam int BYTES  = WORD_W / 8,
  localparam int BOFF_W = $clog2(BYTES),
  localparam int WOFF_W = $clog2(LINE_WORDS),
  localparam int IDX_W  = $clog2(SETS),
  localparam int TAG_W  = ADDR_W - IDX_W - WOFF_W - BOFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [WORD_W-1:0] cpu_wdata,
  input  logic [BYTES-1:0]  cpu_mask,
  input  logic              cpu_rd,
  input  logic              cpu_wr,
  output logic [WORD_W-1:0] cpu_rdata,
  output logic              cpu_stall,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  output logic [BYTES-1:0]  mem_mask,
  output logic              mem_rd,
  output logic              mem_wr,
  input  logic [WORD_W-1:0] mem_rdata,
  input  logic              mem_stall
);
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  logic [TAG_W-1:0]  req_tag;
  logic [IDX_W-1:0]  req_idx;
  logic [WOFF_W-1:0] req_word;
  logic              unused_boff;
  assign req_tag     = cpu_addr[ADDR_W-1 -: TAG_W];
  assign req_idx     = cpu_addr[BOFF_W+WOFF_W +: IDX_W];
  assign req_word    = cpu_addr[BOFF_W +: WOFF_W];
  assign unused_boff = ^cpu_addr[BOFF_W-1:0];

  wbdc_state_e       state;
  logic [WOFF_W-1:0] beat;
  logic [IDX_W-1:0]  flush_idx;
  logic clr_en, fill_word_en, fill_done, latch_en, upd_en;
  logic rd_valid, rd_dirty, hit, victim_dirty;
  logic [TAG_W-1:0] rd_tag;

  assign hit          = rd_valid && (rd_tag == req_tag);
  assign victim_dirty = rd_valid && rd_dirty;

  logic [IDX_W-1:0]  upd_idx_q;
  logic [WOFF_W-1:0] upd_word_q;
  logic [WORD_W-1:0] upd_data_q;
  logic [BYTES-1:0]  upd_be_q;

  always_ff @(posedge clk) begin
    if (latch_en) begin
      upd_idx_q  <= req_idx;
      upd_word_q <= req_word;
      upd_data_q <= cpu_wdata;
      upd_be_q   <= cpu_mask;
    end
  end

  wbdc_ctrl #(.SETS(SETS), .LINE_WORDS(LINE_WORDS)) ctrl_i (
    .clk(clk), .rst_n(rst_sync_n),
    .req_rd(cpu_rd), .req_wr(cpu_wr), .hit(hit), .victim_dirty(victim_dirty),
    .mem_stall(mem_stall), .state(state), .beat(beat), .flush_idx(flush_idx),
    .clr_en(clr_en), .fill_word_en(fill_word_en), .fill_done(fill_done),
    .latch_en(latch_en), .upd_en(upd_en), .cpu_stall(cpu_stall),
    .mem_rd(mem_rd), .mem_wr(mem_wr)
  );

  wbdc_tag_store #(.SETS(SETS), .TAG_W(TAG_W)) tags_i (
    .clk(clk), .rst_n(rst_sync_n),
    .rd_idx(req_idx), .rd_valid(rd_valid), .rd_dirty(rd_dirty), .rd_tag(rd_tag),
    .clr_en(clr_en), .clr_idx(flush_idx),
    .fill_en(fill_done), .fill_idx(req_idx), .fill_tag(req_tag),
    .dirty_en(upd_en), .dirty_idx(upd_idx_q)
  );

  logic [WOFF_W-1:0] line_rd_word;
  logic [WORD_W-1:0] line_rd_data;
  logic              line_wr_en;
  logic [IDX_W-1:0]  line_wr_set;
  logic [WOFF_W-1:0] line_wr_word;
  logic [WORD_W-1:0] line_wr_data;
  logic [BYTES-1:0]  line_wr_be;

  assign line_rd_word = (state == ST_WBACK) ? beat : req_word;
  assign line_wr_en   = fill_word_en | upd_en;
  assign line_wr_set  = fill_word_en ? req_idx   : upd_idx_q;
  assign line_wr_word = fill_word_en ? beat      : upd_word_q;
  assign line_wr_data = fill_word_en ? mem_rdata : upd_data_q;
  assign line_wr_be   = fill_word_en ? {BYTES{1'b1}} : upd_be_q;

  wbdc_line_store #(.SETS(SETS), .LINE_WORDS(LINE_WORDS), .WORD_W(WORD_W)) lines_i (
    .clk(clk), .rst_n(rst_sync_n),
    .rd_set(req_idx), .rd_word(line_rd_word), .rd_data(line_rd_data),
    .wr_en(line_wr_en), .wr_set(line_wr_set), .wr_word(line_wr_word),
    .wr_data(line_wr_data), .wr_be(line_wr_be)
  );

  assign cpu_rdata = line_rd_data;
  assign mem_wdata = mem_wr ? line_rd_data : '0;
  assign mem_mask  = mem_wr ? {BYTES{1'b1}} : '0;

  always_comb begin
    mem_addr = '0;
    if (mem_wr)      mem_addr = {rd_tag,  req_idx, beat, {BOFF_W{1'b0}}};
    else if (mem_rd) mem_addr = {req_tag, req_idx, beat, {BOFF_W{1'b0}}};
  end

  // R3: a completed load hit leaves memory quiet
  p_hit_quiet_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cpu_rd && !cpu_stall) |-> (!mem_rd && !mem_wr));

  // R10: write beats carry a full mask
  p_wr_full_mask_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    mem_wr |-> (mem_mask == {BYTES{1'b1}}));
endmodule

// File: tb/wbdc_top_tb_top.sv
module wbdc_top_tb_top;
  localparam int ADDR_W = 12;
  localparam int WORD_W = 32;
  localparam int SETS   = 8;
  localparam int MWORDS = 1 << (ADDR_W - 2);

  logic              clk = 1'b0;
  logic              rst_n;
  logic [ADDR_W-1:0] cpu_addr;
  logic [WORD_W-1:0] cpu_wdata;
  logic [3:0]        cpu_mask;
  logic              cpu_rd, cpu_wr;
  logic [WORD_W-1:0] cpu_rdata;
  logic              cpu_stall;
  logic [ADDR_W-1:0] mem_addr;
  logic [WORD_W-1:0] mem_wdata;
  logic [3:0]        mem_mask;
  logic              mem_rd, mem_wr;
  logic [WORD_W-1:0] mem_rdata;
  logic              mem_stall;

  always #2.5 clk = ~clk;

  wbdc_top dut_i (
    .clk(clk), .rst_n(rst_n),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_mask(cpu_mask),
    .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_rdata(cpu_rdata), .cpu_stall(cpu_stall),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_mask(mem_mask),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_rdata(mem_rdata), .mem_stall(mem_stall)
  );

  logic [WORD_W-1:0] bmem    [MWORDS];
  logic [WORD_W-1:0] ref_mem [MWORDS];
  int n_checks = 0, n_fail = 0;
  int rd_beats = 0, wr_beats = 0, mon_err = 0;
  logic stall_mode = 1'b0;

  assign mem_rdata = bmem[mem_addr[ADDR_W-1:2]];

  always @(negedge clk) mem_stall <= stall_mode ? ~mem_stall : 1'b0;

  always @(posedge clk) begin
    if (rst_n) begin
      if (mem_rd && mem_wr) mon_err++;
      if (mem_wr && mem_mask != 4'hF) mon_err++;
      if (mem_wr && !mem_stall) begin
        bmem[mem_addr[ADDR_W-1:2]] <= mem_wdata;
        wr_beats++;
      end
      if (mem_rd && !mem_stall) rd_beats++;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] merge(input logic [31:0] o, input logic [31:0] d,
                                        input logic [3:0] m);
    logic [31:0] r = o;
    for (int b = 0; b < 4; b++) if (m[b]) r[b*8 +: 8] = d[b*8 +: 8];
    return r;
  endfunction

  // Issues one request, holds it until stall is low, returns data and cycle count.
  task automatic access(input logic wr, input logic [ADDR_W-1:0] a,
                        input logic [31:0] d, input logic [3:0] m,
                        output logic [31:0] rdata, output int cyc);
    cyc = 0;
    rdata = '0;
    cpu_addr = a; cpu_wdata = d; cpu_mask = m; cpu_rd = !wr; cpu_wr = wr;
    forever begin
      #1;
      if (!cpu_stall) begin
        rdata = cpu_rdata;
        @(posedge clk);
        cyc++;
        break;
      end
      @(posedge clk);
      cyc++;
      if (cyc > 2000) begin
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual %0d expected <2000", cyc);
        break;
      end
      @(negedge clk);
    end
    @(negedge clk);
    cpu_rd = 1'b0; cpu_wr = 1'b0;
    if (wr) ref_mem[a[ADDR_W-1:2]] = merge(ref_mem[a[ADDR_W-1:2]], d, m);
  endtask

  task automatic t_reset();
    int n = 0;
    rst_n = 1'b0; cpu_rd = 0; cpu_wr = 0; cpu_addr = '0; cpu_wdata = '0; cpu_mask = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1 stall after reset", {31'd0, cpu_stall}, 32'd1);
    while (cpu_stall && n < 100) begin
      @(negedge clk); #1; n++;
    end
    check("R1 sweep length in range", {31'd0, (n >= SETS && n <= SETS + 3)}, 32'd1);
    @(negedge clk);
  endtask

  task automatic t_read_miss();
    logic [31:0] r; int c; int rb = rd_beats, wb = wr_beats;
    stall_mode = 1'b1;
    access(1'b0, 12'h0A4, '0, '0, r, c);
    stall_mode = 1'b0;
    check("R4 refill data", r, ref_mem[12'h0A4 >> 2]);
    check("R4 refill beats", rd_beats - rb, 32'd4);
    check("R1 invalid line, no write-back", wr_beats - wb, 32'd0);
  endtask

  task automatic t_read_hit();
    logic [31:0] r; int c; int rb = rd_beats;
    access(1'b0, 12'h0AC, '0, '0, r, c);
    check("R3 hit data", r, ref_mem[12'h0AC >> 2]);
    check("R3 hit cycles", c, 32'd1);
    check("R3 no memory beats", rd_beats - rb, 32'd0);
  endtask

  task automatic t_write_hit();
    logic [31:0] r; int c;
    access(1'b1, 12'h0A4, 32'h1122_3344, 4'b0001, r, c);
    check("R7 store hit cycles", c, 32'd1);
    access(1'b0, 12'h0A4, '0, '0, r, c);
    check("R9 chained load cycles", c, 32'd2);
    check("R7 byte merge", r, ref_mem[12'h0A4 >> 2]);
    access(1'b1, 12'h0A8, 32'hDEAD_BEEF, 4'b1100, r, c);
    access(1'b0, 12'h0A8, '0, '0, r, c);
    check("R7 half-word merge", r, ref_mem[12'h0A8 >> 2]);
  endtask

  task automatic t_write_miss();
    logic [31:0] r; int c; int rb = rd_beats, wb = wr_beats;
    access(1'b1, 12'h0D0, 32'hCAFE_F00D, 4'b1111, r, c);
    check("R4 store miss refill beats", rd_beats - rb, 32'd4);
    check("R5 no write-back for invalid victim", wr_beats - wb, 32'd0);
    access(1'b0, 12'h0D0, '0, '0, r, c);
    check("R7 word store after allocate", r, 32'hCAFE_F00D);
  endtask

  task automatic t_evict_dirty();
    logic [31:0] r; int c; int rb = rd_beats, wb = wr_beats;
    access(1'b0, 12'h1A0, '0, '0, r, c);
    check("R5 write-back beats", wr_beats - wb, 32'd4);
    check("R5 refill after write-back", rd_beats - rb, 32'd4);
    check("R4 new line data", r, ref_mem[12'h1A0 >> 2]);
    for (int w = 0; w < 4; w++)
      check("R8 written-back word", bmem[(12'h0A0 >> 2) + w], ref_mem[(12'h0A0 >> 2) + w]);
  endtask

  task automatic t_evict_clean();
    logic [31:0] r; int c; int rb = rd_beats, wb = wr_beats;
    access(1'b0, 12'h0A4, '0, '0, r, c);
    check("R6 clean victim, no write-back", wr_beats - wb, 32'd0);
    check("R6 refill beats", rd_beats - rb, 32'd4);
    check("R8 stored byte back from memory", r, ref_mem[12'h0A4 >> 2]);
  endtask

  task automatic t_idle();
    logic [31:0] r; int c;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); #1;
      check("R2 idle stall low", {31'd0, cpu_stall}, 32'd0);
    end
    @(negedge clk);
    access(1'b0, 12'h0A8, '0, '0, r, c);
    check("R2 hit from idle cycles", c, 32'd2);
    check("R2 hit from idle data", r, ref_mem[12'h0A8 >> 2]);
  endtask

  initial begin
    for (int i = 0; i < MWORDS; i++) begin
      bmem[i]    = (i * 32'h9E37_79B9) ^ 32'h5A5A_0000;
      ref_mem[i] = (i * 32'h9E37_79B9) ^ 32'h5A5A_0000;
    end
    mem_stall = 1'b0;
    @(negedge clk);
    t_reset();
    t_read_miss();
    t_read_hit();
    t_write_hit();
    t_write_miss();
    t_evict_dirty();
    t_evict_clean();
    t_idle();
    check("R10 memory strobe and mask rules", mon_err, 32'd0);
    $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #500000;
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule